// File: doc/BRIEF.md
# Passive Display Adaptor Identification Engine

This block runs once per hotplug event and works out what kind of passive dual-mode display adaptor, if any, sits on the connector. It asks a simple I2C master to probe the adaptor's register block at a fixed device address. Each probe writes register offset zero and then reads a fixed number of bytes back. If a probe fails, the block tries again, up to a fixed limit.

The returned bytes stream through the block one at a time and are never stored in full. A matcher compares the identification text and the terminator byte as they pass. It also captures the type-2 marker byte and the TMDS limit byte. When a probe completes, a small decoder turns the limit byte into a clock value in MHz and checks it against an accepted range. The engine then publishes a dongle-type code and a maximum pixel clock in kHz, together with a one-cycle completion pulse.

Top module: `adp_id_engine`

## Requirements
- R1: After reset, `type_o` is 0 (none), `max_clk_khz_o` equals SAFE_KHZ, and both `done_o` and `i2c_req_o` are low.
- R2: A `hpd_i` pulse while idle sets `type_o` to 0 and `max_clk_khz_o` to SAFE_KHZ. Every probe request then carries device address 0x40, start offset 0 and a length of 30 bytes.
- R3: A failed probe (`i2c_done_i` with `i2c_ok_i` low) starts a new probe after `i2c_req_o` has been low for at least one cycle. At most 3 probes are made per hotplug.
- R4: If all 3 probes fail, the result is type 1 (DVI) with `max_clk_khz_o` equal to DVI_KHZ.
- R5: Bytes 0 to 14 are compared against the ASCII text "DP-HDMI ADAPTOR", and any difference at byte index 3 is never counted. Byte 15 must be 0x04; if it is not, the terminator is bad.
- R6: The adaptor counts as type 2 when byte 16 (offset 0x10) is 0xA0. Its limit in MHz is r*2 + r/2 with integer division, where r is byte 29 (offset 0x1D).
- R7: A type-2 adaptor whose limit is 0, below 25 or above 600 MHz is reported as type 1 (DVI), and `max_clk_khz_o` keeps SAFE_KHZ.
- R8: A type-2 adaptor with a limit in range is reported as type 2 (HDMI) when the text and the terminator both match, and as type 3 (HDMI, mismatched) otherwise. `max_clk_khz_o` is the limit times 1000.
- R9: For an adaptor that is not type 2, text differences are ignored. A bad terminator gives type 3; a good one gives type 2. `max_clk_khz_o` stays SAFE_KHZ.
- R10: `done_o` is a single-cycle pulse that appears in the same cycle as the final result. A `hpd_i` pulse while a probe is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hpd_i | input | 1 | Hotplug pulse that starts identification |
| i2c_req_o | output | 1 | Probe request, held until the master reports completion |
| i2c_addr_o | output | 7 | 7-bit device address for the probe |
| i2c_offset_o | output | 8 | Register offset written before the read |
| i2c_len_o | output | 8 | Number of bytes to read |
| i2c_byte_vld_i | input | 1 | A read byte is present on `i2c_byte_i` |
| i2c_byte_i | input | 8 | Read byte, delivered in address order |
| i2c_done_i | input | 1 | Probe complete, one-cycle pulse |
| i2c_ok_i | input | 1 | Probe succeeded; sampled together with `i2c_done_i` |
| type_o | output | 3 | Adaptor type: 0 none, 1 DVI, 2 HDMI, 3 HDMI mismatched |
| max_clk_khz_o | output | 20 | Maximum pixel clock in kHz |
| done_o | output | 1 | One-cycle pulse when the result is final |

## Verification
The table drives adaptors with and without the type-2 marker. The text is either clean or broken at byte 3 or at another byte, and the terminator is either good or bad. Together these show that byte 3 is skipped and that a text error changes the result only for type 2. Limit bytes are chosen at each end of the range and one step beyond it (9, 10, 240, 241), plus zero and an odd value, which exposes any error in the 2.5 scaling and in the range edges. Probe sequences with zero, two and three failures check both the retry count and the fall-back to DVI. A bench-chosen DVI clock that differs from the safe default shows which of the two values each path reports.

// File: rtl/adp_id_pkg.sv
package adp_id_pkg;

  typedef enum logic [2:0] {
    DT_NONE          = 3'd0,
    DT_DVI           = 3'd1,
    DT_HDMI          = 3'd2,
    DT_HDMI_MISMATCH = 3'd3
  } dongle_t;

  localparam int SIG_LEN   = 15;
  localparam int SKIP_IDX  = 3;
  localparam int EOT_OFS   = 15;
  localparam int ID_OFS    = 16;
  localparam int TMDS_OFS  = 29;
  localparam int BLOCK_LEN = 30;
  localparam logic [7:0] EOT_VAL  = 8'h04;
  localparam logic [7:0] ID_TYPE2 = 8'hA0;
  localparam logic [8*SIG_LEN-1:0] SIG_STR = "DP-HDMI ADAPTOR";

  function automatic logic [7:0] sig_char(input logic [4:0] idx);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 0; k < SIG_LEN; k++)
      if (int'(idx) == k) c = SIG_STR[8*(SIG_LEN-1-k) +: 8];
    return c;
  endfunction

endpackage

// File: rtl/adp_sig_matcher.sv
module adp_sig_matcher
  import adp_id_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  output logic       sig_bad_o,
  output logic       eot_bad_o,
  output logic       type2_o,
  output logic [7:0] tmds_reg_o
);

  localparam int IDX_W = $clog2(BLOCK_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;
  logic             sig_bad_q, eot_bad_q;
  logic [7:0]       id_q, tmds_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      sig_bad_q <= 1'b0;
      eot_bad_q <= 1'b1;
      id_q      <= '0;
      tmds_q    <= '0;
    end else if (clr_i) begin
      idx_q     <= '0;
      sig_bad_q <= 1'b0;
      eot_bad_q <= 1'b1;   // no terminator seen yet
      id_q      <= '0;
      tmds_q    <= '0;
    end else if (vld_i) begin
      if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      if (int'(idx_q) < SIG_LEN && int'(idx_q) != SKIP_IDX &&
          byte_i != sig_char(5'(idx_q)))
        sig_bad_q <= 1'b1;
      if (int'(idx_q) == EOT_OFS)  eot_bad_q <= (byte_i != EOT_VAL);
      if (int'(idx_q) == ID_OFS)   id_q      <= byte_i;
      if (int'(idx_q) == TMDS_OFS) tmds_q    <= byte_i;
    end
  end

  assign sig_bad_o  = sig_bad_q;
  assign eot_bad_o  = eot_bad_q;
  assign type2_o    = (id_q == ID_TYPE2);
  assign tmds_reg_o = tmds_q;

  // R5
  clr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (eot_bad_o && !sig_bad_o && !type2_o && tmds_reg_o == 8'h00));

endmodule

// File: rtl/adp_tmds_decode.sv
module adp_tmds_decode #(
  parameter int MIN_MHZ = 25,
  parameter int MAX_MHZ = 600,
  parameter int KHZ_W   = 20
) (
  input  logic [7:0]       reg_i,
  output logic             in_range_o,
  output logic [KHZ_W-1:0] khz_o
);

  localparam int MHZ_W = 10;

  logic [MHZ_W-1:0] mhz;

  // x2.5 with the half truncated
  assign mhz = {1'b0, reg_i, 1'b0} + {2'b00, reg_i[7:1]};

  assign in_range_o = (mhz != '0) && (mhz >= MHZ_W'(MIN_MHZ)) &&
                      (mhz <= MHZ_W'(MAX_MHZ));
  assign khz_o = KHZ_W'(mhz) * KHZ_W'(1000);

  // R7
  always_comb begin
    if (in_range_o)
      tmds_range_chk: assert (khz_o >= KHZ_W'(MIN_MHZ * 1000) &&
                              khz_o <= KHZ_W'(MAX_MHZ * 1000));
  end

endmodule

// File: rtl/adp_id_engine.sv
module adp_id_engine
  import adp_id_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h40,
  parameter int         MAX_TRIES = 3,
  parameter int         SAFE_KHZ  = 165000,
  parameter int         DVI_KHZ   = 165000,
  parameter int         MIN_MHZ   = 25,
  parameter int         MAX_MHZ   = 600,
  parameter int         KHZ_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hpd_i,
  output logic             i2c_req_o,
  output logic [6:0]       i2c_addr_o,
  output logic [7:0]       i2c_offset_o,
  output logic [7:0]       i2c_len_o,
  input  logic             i2c_byte_vld_i,
  input  logic [7:0]       i2c_byte_i,
  input  logic             i2c_done_i,
  input  logic             i2c_ok_i,
  output logic [2:0]       type_o,
  output logic [KHZ_W-1:0] max_clk_khz_o,
  output logic             done_o
);

  localparam int ATT_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [ATT_W-1:0] LAST_TRY = ATT_W'(MAX_TRIES - 1);
  localparam logic [KHZ_W-1:0] SAFE_V   = KHZ_W'(SAFE_KHZ);
  localparam logic [KHZ_W-1:0] DVI_V    = KHZ_W'(DVI_KHZ);

  typedef enum logic [1:0] {ST_IDLE, ST_CLEAR, ST_PROBE, ST_DECIDE} state_t;

  state_t           state_q;
  logic [ATT_W-1:0] attempt_q;
  dongle_t          type_q;
  logic [KHZ_W-1:0] clk_q;
  logic             done_q;

  logic             sig_bad, eot_bad, is_type2, in_range;
  logic [7:0]       tmds_reg;
  logic [KHZ_W-1:0] tmds_khz;
  dongle_t          dec_type;
  logic [KHZ_W-1:0] dec_khz;
  logic             sig_valid;

  adp_sig_matcher u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == ST_CLEAR),
    .vld_i      (i2c_byte_vld_i && state_q == ST_PROBE),
    .byte_i     (i2c_byte_i),
    .sig_bad_o  (sig_bad),
    .eot_bad_o  (eot_bad),
    .type2_o    (is_type2),
    .tmds_reg_o (tmds_reg)
  );

  adp_tmds_decode #(
    .MIN_MHZ (MIN_MHZ),
    .MAX_MHZ (MAX_MHZ),
    .KHZ_W   (KHZ_W)
  ) u_tmds (
    .reg_i      (tmds_reg),
    .in_range_o (in_range),
    .khz_o      (tmds_khz)
  );

  // text errors only matter once type 2 is known
  assign sig_valid = !eot_bad && !(is_type2 && sig_bad);

  always_comb begin
    dec_khz = SAFE_V;
    if (is_type2 && !in_range) begin
      dec_type = DT_DVI;
    end else begin
      dec_type = sig_valid ? DT_HDMI : DT_HDMI_MISMATCH;
      if (is_type2) dec_khz = tmds_khz;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      attempt_q <= '0;
      type_q    <= DT_NONE;
      clk_q     <= SAFE_V;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (hpd_i) begin
          type_q    <= DT_NONE;
          clk_q     <= SAFE_V;
          attempt_q <= '0;
          state_q   <= ST_CLEAR;
        end
        ST_CLEAR: state_q <= ST_PROBE;
        ST_PROBE: if (i2c_done_i) begin
          if (i2c_ok_i) begin
            state_q <= ST_DECIDE;
          end else if (attempt_q == LAST_TRY) begin
            type_q  <= DT_DVI;
            clk_q   <= DVI_V;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            attempt_q <= attempt_q + 1'b1;
            state_q   <= ST_CLEAR;
          end
        end
        ST_DECIDE: begin
          type_q  <= dec_type;
          clk_q   <= dec_khz;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign i2c_req_o     = (state_q == ST_PROBE);
  assign i2c_addr_o    = DEV_ADDR;
  assign i2c_offset_o  = 8'h00;
  assign i2c_len_o     = 8'(BLOCK_LEN);
  assign type_o        = type_q;
  assign max_clk_khz_o = clk_q;
  assign done_o        = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  start_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && hpd_i) |=> (type_o == 3'd0 && max_clk_khz_o == SAFE_V));

  // R3
  retry_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i2c_req_o && i2c_done_i && !i2c_ok_i && attempt_q != LAST_TRY) |=> !i2c_req_o);

  // R4
  all_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i2c_req_o && i2c_done_i && !i2c_ok_i && attempt_q == LAST_TRY) |=>
      (done_o && type_o == 3'd1 && max_clk_khz_o == DVI_V));

  // R10
  no_req_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !i2c_req_o);

endmodule

// File: tb/sim_adp_id_engine.sv
`timescale 1ns/1ps
module sim_adp_id_engine;

  localparam int SAFE = 165000;
  localparam int DVI  = 150000;
  localparam logic [8*15-1:0] TXT = "DP-HDMI ADAPTOR";

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpd = 1'b0;
  logic        req;
  logic [6:0]  addr;
  logic [7:0]  offs, len;
  logic        bvld = 1'b0;
  logic [7:0]  bdat = 8'h00;
  logic        idone = 1'b0;
  logic        iok = 1'b0;
  logic [2:0]  typ;
  logic [19:0] khz;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  adp_id_engine #(.SAFE_KHZ(SAFE), .DVI_KHZ(DVI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hpd_i(hpd),
    .i2c_req_o(req), .i2c_addr_o(addr), .i2c_offset_o(offs), .i2c_len_o(len),
    .i2c_byte_vld_i(bvld), .i2c_byte_i(bdat), .i2c_done_i(idone), .i2c_ok_i(iok),
    .type_o(typ), .max_clk_khz_o(khz), .done_o(done)
  );

  typedef struct packed {
    logic [1:0]  fails;
    logic [4:0]  err;     // 31 = no text error
    logic        eot_ok;
    logic [7:0]  id;
    logic [7:0]  tmds;
    logic [2:0]  exp_t;
    logic [19:0] exp_k;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd31, 1'b1, 8'h00, 8'd0,   3'd2, 20'(SAFE)},   // R9 type1 clean
    '{2'd0, 5'd5,  1'b1, 8'h00, 8'd60,  3'd2, 20'(SAFE)},   // R9 type1 text err ignored
    '{2'd0, 5'd31, 1'b0, 8'h00, 8'd0,   3'd3, 20'(SAFE)},   // R9 type1 bad eot
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd60,  3'd2, 20'd150000},  // R8 type2 clean
    '{2'd0, 5'd3,  1'b1, 8'hA0, 8'd120, 3'd2, 20'd300000},  // R5 byte3 skipped
    '{2'd0, 5'd7,  1'b1, 8'hA0, 8'd120, 3'd3, 20'd300000},  // R8 mismatch
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd0,   3'd1, 20'(SAFE)},   // R7 zero
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd9,   3'd1, 20'(SAFE)},   // R7 22 MHz
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd10,  3'd2, 20'd25000},   // R6 25 MHz edge
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd240, 3'd2, 20'd600000},  // R6 600 MHz edge
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd241, 3'd1, 20'(SAFE)},   // R7 602 MHz
    '{2'd0, 5'd31, 1'b1, 8'hA0, 8'd11,  3'd2, 20'd27000},   // R6 odd halving
    '{2'd2, 5'd31, 1'b1, 8'h00, 8'd0,   3'd2, 20'(SAFE)},   // R3 two fails
    '{2'd3, 5'd31, 1'b1, 8'h00, 8'd0,   3'd1, 20'(DVI)},    // R4 all fail
    '{2'd0, 5'd31, 1'b0, 8'hA0, 8'd60,  3'd3, 20'd150000}   // R8 bad eot type2
  };

  task automatic check(input logic ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input vec_t v, input int i);
    logic [7:0] b;
    b = 8'h00;
    if (i < 15) b = TXT[8*(14-i) +: 8];
    if (i == 15) b = v.eot_ok ? 8'h04 : 8'h05;
    if (i == 16) b = v.id;
    if (i == 29) b = v.tmds;
    if (int'(v.err) == i) b = b ^ 8'h01;
    return b;
  endfunction

  task automatic wait_req(output logic got);
    got = 1'b0;
    for (int c = 0; c < 50 && !got; c++) begin
      @(negedge clk);
      got = req;
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag, input logic busy_hpd);
    int attempts = 0;
    logic got;
    logic fin;
    @(negedge clk);
    hpd = 1'b1;
    @(negedge clk);
    hpd = 1'b0;
    for (int a = 0; a < 3; a++) begin
      wait_req(got);
      if (!got) break;
      attempts++;
      if (a == 0) begin
        check(typ == 3'd0 && khz == 20'(SAFE), {tag, " R2 defaults"}, int'(typ), 0);
        check(addr == 7'h40 && offs == 8'h00 && len == 8'd30, {tag, " R2 probe fields"},
              int'(addr), 'h40);
      end
      if (busy_hpd) begin
        hpd = 1'b1;
        @(negedge clk);
        hpd = 1'b0;
      end
      if (a < int'(v.fails)) begin
        @(negedge clk);
        idone = 1'b1; iok = 1'b0;
        @(negedge clk);
        idone = 1'b0;
        check(!req, {tag, " R3 gap"}, int'(req), 0);
      end else begin
        for (int i = 0; i < 30; i++) begin
          bvld = 1'b1; bdat = byte_at(v, i);
          @(negedge clk);
        end
        bvld = 1'b0;
        idone = 1'b1; iok = 1'b1;
        @(negedge clk);
        idone = 1'b0; iok = 1'b0;
        break;
      end
    end
    fin = done;
    for (int c = 0; c < 20 && !fin; c++) begin
      @(negedge clk);
      fin = done;
    end
    check(fin, {tag, " R10 done seen"}, int'(fin), 1);
    check(typ == v.exp_t, {tag, " type"}, int'(typ), int'(v.exp_t));
    check(khz == v.exp_k, {tag, " clock"}, int'(khz), int'(v.exp_k));
    check(attempts == ((v.fails == 2'd3) ? 3 : int'(v.fails) + 1), {tag, " R3 attempts"},
          attempts, int'(v.fails) + 1);
    @(negedge clk);
    check(!done && !req, {tag, " R10 single pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(typ == 3'd0 && khz == 20'(SAFE) && !done && !req, "R1 reset", int'(typ), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n < NV; n++)
      run_vec(VECS[n], $sformatf("vec%0d", n), 1'b0);
    // R10 hpd while probing is ignored
    run_vec(VECS[3], "busy_hpd R10", 1'b1);
    // R2 new hpd after a DVI result resets outputs before the probe
    run_vec(VECS[13], "refail R4", 1'b0);
    run_vec(VECS[0], "after_dvi R2", 1'b0);
    // R1 reset mid-probe returns to idle state
    @(negedge clk);
    hpd = 1'b1;
    @(negedge clk);
    hpd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!req && typ == 3'd0 && khz == 20'(SAFE), "R1 reset mid-probe", int'(req), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule